// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer with Software Refill

This block maps 40-bit virtual addresses onto 36-bit physical addresses, using 16 KB pages. It holds 512 translations, arranged as 256 sets of two ways. A lookup presents a virtual address, a read/write flag and a user/kernel flag. In the same cycle the block answers with a hit, the physical address and a 2-bit fault code. The block never reads memory. When no translation is present, it raises a miss fault. Privileged software then installs the entry through a kernel-qualified install port, naming the set and the way.

Each entry carries four state fields: a valid flag, a dirty flag, a 2-bit rights field and a reference flag. The reference flag records recent use and feeds a replacement hint for the addressed set. The operating system clears all reference flags at once with a single command. The dirty flag must be set before the block accepts a write. A write to a clean page raises a "modified" fault, so software can mark the page and then reinstall the entry.

Top module: `vtlb_2way`

## Requirements
- R1: The set index is VA[21:14] and the tag is VA[39:22]. On a hit, `lk_pa` equals the stored 22-bit page number followed by VA[13:0], and `lk_fault` is 0.
- R2: A lookup (`lk_req`=1) with no valid entry of matching tag in the set gives `lk_fault`=1 (miss), `lk_exc`=1 and `lk_hit`=0.
- R3: The rights field is encoded as follows: 00 allows no access, 01 allows reads only, 10 allows reads and writes, 11 allows reads and writes in kernel mode only (`lk_user`=0). An access that the rights forbid gives `lk_fault`=2, `lk_exc`=1 and `lk_hit`=0.
- R4: A write that the rights allow, to an entry whose dirty flag is clear, gives `lk_fault`=3, `lk_exc`=1 and `lk_hit`=0.
- R5: A hit sets the reference flag of the used entry at the next clock edge.
- R6: With `sw_kernel`=1, `clr_ref` clears every reference flag at the next edge, and this takes precedence over a hit in the same cycle.
- R7: With `sw_kernel`=1, `wr_en` writes the valid, dirty, rights, tag and page-number fields into way `wr_way` of set `wr_set` at the next edge, and clears that entry's reference flag. With `sw_kernel`=0, installs and clears are ignored.
- R8: When both ways of the set match, way 0 is used for the result and `lk_multi` is 1 (only while `lk_req`=1).
- R9: `lk_victim` names the way to replace in the set addressed by `lk_va`. The choice is the lowest invalid way if there is one; otherwise the lowest way whose reference flag is clear; otherwise way 0.
- R10: Reset clears every valid flag and every reference flag. After reset, every lookup misses and `lk_victim` is 0.
- R11: With `lk_req`=0, `lk_hit`, `lk_exc` and `lk_multi` are 0, `lk_fault` is 0, and no reference flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 40 | Virtual address |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Translation succeeded |
| lk_pa | output | 36 | Physical address (meaningful on hit) |
| lk_fault | output | 2 | 0 none, 1 miss, 2 protection, 3 modified |
| lk_exc | output | 1 | Exception raised (fault code nonzero) |
| lk_multi | output | 1 | Both ways matched |
| lk_victim | output | 1 | Replacement way hint for the addressed set |
| sw_kernel | input | 1 | Privilege qualifier for install and clear |
| wr_en | input | 1 | Install strobe |
| wr_set | input | 8 | Set to install into |
| wr_way | input | 1 | Way to install into |
| wr_valid | input | 1 | Valid flag to store |
| wr_dirty | input | 1 | Dirty flag to store |
| wr_rights | input | 2 | Rights field to store |
| wr_tag | input | 18 | Tag to store |
| wr_ppn | input | 22 | Physical page number to store |
| clr_ref | input | 1 | Clear all reference flags |

## Verification
The bench targets several corner cases. It installs duplicate tags in both ways of a set. A design that picked the wrong way would return the wrong page number or leave the multi-hit flag low. It drives every rights code in both modes, on both reads and writes. A mistake there would either let a forbidden access hit or report a protection fault where a modified fault belongs. It also sends installs and clears without the privilege qualifier; a design that accepted them would later hit on an entry software never installed. Finally, it mixes hits, bulk clears and installs in the same cycles and watches the replacement hint. Wrong precedence between those updates shows up as the wrong victim way.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

   typedef enum logic [1:0] {
      RT_NONE = 2'b00,
      RT_RO   = 2'b01,
      RT_RW   = 2'b10,
      RT_KRW  = 2'b11
   } rights_t;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_MISS = 2'd1,
      FLT_PROT = 2'd2,
      FLT_MOD  = 2'd3
   } fault_t;

endpackage

// File: rtl/vtlb_way.sv
module vtlb_way #(
   parameter int SET_W = 8,
   parameter int TAG_W = 18,
   parameter int PPN_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   input  logic [TAG_W-1:0] rd_tag,
   input  logic             hit_upd,
   input  logic             clr_all,
   input  logic             wr_do,
   input  logic [SET_W-1:0] wr_set,
   input  logic             wr_valid,
   input  logic             wr_dirty,
   input  logic [1:0]       wr_rights,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PPN_W-1:0] wr_ppn,
   output logic             ent_match,
   output logic             ent_valid,
   output logic             ent_ref,
   output logic             ent_dirty,
   output logic [1:0]       ent_rights,
   output logic [PPN_W-1:0] ent_ppn
);

   localparam int SETS = 1 << SET_W;

   logic [SETS-1:0]  valid_q;
   logic [SETS-1:0]  ref_q;
   logic             dirty_m  [SETS];
   logic [1:0]       rights_m [SETS];
   logic [TAG_W-1:0] tag_m    [SETS];
   logic [PPN_W-1:0] ppn_m    [SETS];

   // Flags that reset clears live in flops; the bulk fields need no reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         ref_q   <= '0;
      end else begin
         if (clr_all)      ref_q         <= '0;
         else if (hit_upd) ref_q[rd_set] <= 1'b1;
         if (wr_do) begin
            valid_q[wr_set] <= wr_valid;
            ref_q[wr_set]   <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_do) begin
         dirty_m[wr_set]  <= wr_dirty;
         rights_m[wr_set] <= wr_rights;
         tag_m[wr_set]    <= wr_tag;
         ppn_m[wr_set]    <= wr_ppn;
      end
   end

   assign ent_valid  = valid_q[rd_set];
   assign ent_ref    = ref_q[rd_set];
   assign ent_dirty  = dirty_m[rd_set];
   assign ent_rights = rights_m[rd_set];
   assign ent_ppn    = ppn_m[rd_set];
   assign ent_match  = valid_q[rd_set] && (tag_m[rd_set] == rd_tag);

   p_install_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_do |=> (valid_q[$past(wr_set)] == $past(wr_valid)) && !ref_q[$past(wr_set)]);

   p_ref_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_upd && !clr_all && !(wr_do && (wr_set == rd_set))) |=> ref_q[$past(rd_set)]);

   p_ref_bulk_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all && !wr_do) |=> (ref_q == '0));

endmodule

// File: rtl/vtlb_check.sv
module vtlb_check
   import vtlb_pkg::*;
#(
   parameter int WAYS  = 2,
   parameter int WAY_W = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req,
   input  logic                  write,
   input  logic                  user,
   input  logic [WAYS-1:0]       match,
   input  logic [WAYS-1:0]       dirty,
   input  logic [WAYS-1:0][1:0]  rights,
   output logic                  hit,
   output fault_t                fault,
   output logic                  multi,
   output logic [WAY_W-1:0]      sel
);

   logic    any;
   logic    prot;
   logic    clean_wr;
   rights_t r_sel;

   // Lowest-numbered matching way wins.
   always_comb begin
      sel = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (match[i]) sel = WAY_W'(i);
      end
   end

   assign any      = |match;
   assign multi    = req && ((match & (match - 1'b1)) != '0);
   assign r_sel    = rights_t'(rights[sel]);
   assign clean_wr = write && !dirty[sel];

   always_comb begin
      unique case (r_sel)
         RT_NONE: prot = 1'b1;
         RT_RO:   prot = write;
         RT_RW:   prot = 1'b0;
         RT_KRW:  prot = user;
         default: prot = 1'b1;
      endcase
   end

   always_comb begin
      if (!req)          fault = FLT_NONE;
      else if (!any)     fault = FLT_MISS;
      else if (prot)     fault = FLT_PROT;
      else if (clean_wr) fault = FLT_MOD;
      else               fault = FLT_NONE;
   end

   assign hit = req && any && !prot && !clean_wr;

   p_miss_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req && (match == '0)) |-> (fault == FLT_MISS) && !hit);

   p_user_rights_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && user) |-> (rights[sel] == 2'b01 || rights[sel] == 2'b10));

   p_write_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && write) |-> dirty[sel]);

   p_way0_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      match[0] |-> (sel == '0));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req |-> !hit && !multi && (fault == FLT_NONE));

endmodule

// File: rtl/vtlb_victim.sv
module vtlb_victim #(
   parameter int WAYS  = 2,
   parameter int WAY_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WAYS-1:0]  valid,
   input  logic [WAYS-1:0]  refb,
   output logic [WAY_W-1:0] victim
);

   logic got_inv;
   logic got_old;

   always_comb begin
      victim  = '0;
      got_inv = 1'b0;
      got_old = 1'b0;
      for (int i = 0; i < WAYS; i++) begin
         if (!valid[i] && !got_inv) begin
            victim  = WAY_W'(i);
            got_inv = 1'b1;
         end
      end
      if (!got_inv) begin
         for (int i = 0; i < WAYS; i++) begin
            if (!refb[i] && !got_old) begin
               victim  = WAY_W'(i);
               got_old = 1'b1;
            end
         end
      end
   end

   p_victim_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(&valid) |-> !valid[victim]);

   p_victim_unref_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((&valid) && !(&refb)) |-> !refb[victim]);

endmodule

// File: rtl/vtlb_2way.sv
module vtlb_2way
   import vtlb_pkg::*;
#(
   parameter int VA_W  = 40,
   parameter int PA_W  = 36,
   parameter int OFF_W = 14,
   parameter int SET_W = 8,
   parameter int WAYS  = 2
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   lk_req,
   input  logic [VA_W-1:0]                        lk_va,
   input  logic                                   lk_write,
   input  logic                                   lk_user,
   output logic                                   lk_hit,
   output logic [PA_W-1:0]                        lk_pa,
   output logic [1:0]                             lk_fault,
   output logic                                   lk_exc,
   output logic                                   lk_multi,
   output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] lk_victim,
   input  logic                                   sw_kernel,
   input  logic                                   wr_en,
   input  logic [SET_W-1:0]                       wr_set,
   input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] wr_way,
   input  logic                                   wr_valid,
   input  logic                                   wr_dirty,
   input  logic [1:0]                             wr_rights,
   input  logic [VA_W-OFF_W-SET_W-1:0]            wr_tag,
   input  logic [PA_W-OFF_W-1:0]                  wr_ppn,
   input  logic                                   clr_ref
);

   localparam int VPN_W = VA_W - OFF_W;
   localparam int TAG_W = VPN_W - SET_W;
   localparam int PPN_W = PA_W - OFF_W;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   if (VA_W <= OFF_W + SET_W) begin : g_bad_va
      $error("virtual address leaves no tag bits");
   end
   if (PA_W <= OFF_W) begin : g_bad_pa
      $error("physical address leaves no page number");
   end
   if (WAYS < 2) begin : g_bad_ways
      $error("at least two ways are required");
   end

   logic [SET_W-1:0] rd_set;
   logic [TAG_W-1:0] rd_tag;
   logic             inst_ok;
   logic             clr_ok;
   logic [WAY_W-1:0] sel;
   fault_t           fault;

   logic [WAYS-1:0]             w_match;
   logic [WAYS-1:0]             w_valid;
   logic [WAYS-1:0]             w_ref;
   logic [WAYS-1:0]             w_dirty;
   logic [WAYS-1:0][1:0]        w_rights;
   logic [WAYS-1:0][PPN_W-1:0]  w_ppn;

   assign rd_set  = lk_va[OFF_W +: SET_W];
   assign rd_tag  = lk_va[VA_W-1 -: TAG_W];
   assign inst_ok = wr_en && sw_kernel;
   assign clr_ok  = clr_ref && sw_kernel;

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      vtlb_way #(.SET_W(SET_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) i_way (
         .clk        (clk),
         .rst_n      (rst_n),
         .rd_set     (rd_set),
         .rd_tag     (rd_tag),
         .hit_upd    (lk_hit && (sel == WAY_W'(g))),
         .clr_all    (clr_ok),
         .wr_do      (inst_ok && (wr_way == WAY_W'(g))),
         .wr_set     (wr_set),
         .wr_valid   (wr_valid),
         .wr_dirty   (wr_dirty),
         .wr_rights  (wr_rights),
         .wr_tag     (wr_tag),
         .wr_ppn     (wr_ppn),
         .ent_match  (w_match[g]),
         .ent_valid  (w_valid[g]),
         .ent_ref    (w_ref[g]),
         .ent_dirty  (w_dirty[g]),
         .ent_rights (w_rights[g]),
         .ent_ppn    (w_ppn[g])
      );
   end

   vtlb_check #(.WAYS(WAYS), .WAY_W(WAY_W)) i_check (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (lk_req),
      .write  (lk_write),
      .user   (lk_user),
      .match  (w_match),
      .dirty  (w_dirty),
      .rights (w_rights),
      .hit    (lk_hit),
      .fault  (fault),
      .multi  (lk_multi),
      .sel    (sel)
   );

   vtlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) i_victim (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (w_valid),
      .refb   (w_ref),
      .victim (lk_victim)
   );

   assign lk_fault = fault;
   assign lk_exc   = (fault != FLT_NONE);
   assign lk_pa    = {w_ppn[sel], lk_va[OFF_W-1:0]};

   p_hit_pa_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]) && !lk_exc);

   p_no_install_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sw_kernel && !clr_ref && !lk_req) |=> $stable(w_valid) || $changed(rd_set));

endmodule

// File: tb/test_vtlb_2way.sv
`timescale 1ns/1ps
module test_vtlb_2way;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [39:0] lk_va = '0;
   logic        lk_write = 1'b0;
   logic        lk_user = 1'b0;
   logic        lk_hit;
   logic [35:0] lk_pa;
   logic [1:0]  lk_fault;
   logic        lk_exc;
   logic        lk_multi;
   logic [0:0]  lk_victim;
   logic        sw_kernel = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_set = '0;
   logic [0:0]  wr_way = '0;
   logic        wr_valid = 1'b0;
   logic        wr_dirty = 1'b0;
   logic [1:0]  wr_rights = '0;
   logic [17:0] wr_tag = '0;
   logic [21:0] wr_ppn = '0;
   logic        clr_ref = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   vtlb_2way i_vtlb_2way (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
      .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit), .lk_pa(lk_pa),
      .lk_fault(lk_fault), .lk_exc(lk_exc), .lk_multi(lk_multi),
      .lk_victim(lk_victim), .sw_kernel(sw_kernel), .wr_en(wr_en),
      .wr_set(wr_set), .wr_way(wr_way), .wr_valid(wr_valid),
      .wr_dirty(wr_dirty), .wr_rights(wr_rights), .wr_tag(wr_tag),
      .wr_ppn(wr_ppn), .clr_ref(clr_ref)
   );

   // Behavioural reference model
   bit          mv   [2][256];
   bit          mref [2][256];
   bit          md   [2][256];
   logic [1:0]  mr   [2][256];
   logic [17:0] mt   [2][256];
   logic [21:0] mp   [2][256];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
   endtask

   task automatic model_cycle();
      int    s;
      int    sw;
      bit    m0, m1, prot, modf, eh;
      int    ef;
      int    ev;
      string t;
      s  = int'(lk_va[21:14]);
      m0 = mv[0][s] && (mt[0][s] == lk_va[39:22]);
      m1 = mv[1][s] && (mt[1][s] == lk_va[39:22]);
      sw = m0 ? 0 : 1;
      case (mr[sw][s])
         2'b00:   prot = 1'b1;
         2'b01:   prot = lk_write;
         2'b10:   prot = 1'b0;
         default: prot = lk_user;
      endcase
      modf = lk_write && !md[sw][s];
      if (!lk_req)          begin ef = 0; t = "R11"; end
      else if (!(m0 || m1)) begin ef = 1; t = "R2";  end
      else if (prot)        begin ef = 2; t = "R3";  end
      else if (modf)        begin ef = 3; t = "R4";  end
      else                  begin ef = 0; t = "R1";  end
      eh = lk_req && (m0 || m1) && (ef == 0);
      chk(t, {61'd0, lk_hit, lk_exc, lk_fault}, {61'd0, eh, ef != 0, 2'(ef)});
      if (eh) chk("R1", 64'(lk_pa), 64'({mp[sw][s], lk_va[13:0]}));
      chk("R8", 64'(lk_multi), 64'(lk_req && m0 && m1));
      if (!mv[0][s])       ev = 0;
      else if (!mv[1][s])  ev = 1;
      else if (!mref[0][s]) ev = 0;
      else if (!mref[1][s]) ev = 1;
      else                  ev = 0;
      chk("R9", 64'(lk_victim), 64'(ev));
      // state update for the coming edge
      if (sw_kernel && clr_ref) begin
         for (int w = 0; w < 2; w++)
            for (int i = 0; i < 256; i++) mref[w][i] = 1'b0;
      end else if (eh) begin
         mref[sw][s] = 1'b1;
      end
      if (sw_kernel && wr_en) begin
         mv[wr_way][wr_set]   = wr_valid;
         md[wr_way][wr_set]   = wr_dirty;
         mr[wr_way][wr_set]   = wr_rights;
         mt[wr_way][wr_set]   = wr_tag;
         mp[wr_way][wr_set]   = wr_ppn;
         mref[wr_way][wr_set] = 1'b0;
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < 2; w++)
            for (int i = 0; i < 256; i++) begin
               mv[w][i]   = 1'b0;
               mref[w][i] = 1'b0;
            end
      end else begin
         model_cycle();
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual hung expected finish");
         summary();
         $finish;
      end
   end

   function automatic logic [39:0] mkva(input logic [17:0] t, input logic [7:0] s,
                                        input logic [13:0] o);
      return {t, s, o};
   endfunction

   task automatic install(input bit k, input bit way, input logic [7:0] s, input bit v,
                          input bit d, input logic [1:0] r, input logic [17:0] t,
                          input logic [21:0] p);
      @(posedge clk) #1;
      lk_req = 1'b0; clr_ref = 1'b0;
      sw_kernel = k; wr_en = 1'b1; wr_way = way; wr_set = s; wr_valid = v;
      wr_dirty = d; wr_rights = r; wr_tag = t; wr_ppn = p;
      @(posedge clk) #1;
      wr_en = 1'b0; sw_kernel = 1'b0;
   endtask

   task automatic look(input bit rq, input logic [39:0] va, input bit wr, input bit usr);
      @(posedge clk) #1;
      wr_en = 1'b0; clr_ref = 1'b0; sw_kernel = 1'b0;
      lk_req = rq; lk_va = va; lk_write = wr; lk_user = usr;
      @(negedge clk);
   endtask

   task automatic wipe_refs();
      @(posedge clk) #1;
      lk_req = 1'b0; wr_en = 1'b0; sw_kernel = 1'b1; clr_ref = 1'b1;
      @(posedge clk) #1;
      clr_ref = 1'b0; sw_kernel = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10: reset state
      look(1'b1, mkva(18'h3, 8'd5, 14'h12), 1'b0, 1'b0);
      chk("R10", 64'(lk_fault), 64'd1);
      chk("R10", 64'(lk_victim), 64'd0);

      // R1 and R7: install and hit with address composition
      install(1'b1, 1'b0, 8'd5, 1'b1, 1'b1, 2'b10, 18'h2AAAA, 22'h155555);
      look(1'b1, mkva(18'h2AAAA, 8'd5, 14'h3ABC), 1'b1, 1'b1);
      chk("R1", 64'(lk_hit), 64'd1);
      chk("R1", 64'(lk_pa), 64'({22'h155555, 14'h3ABC}));

      // R11: no request, nothing reported
      look(1'b0, mkva(18'h2AAAA, 8'd5, 14'h0), 1'b0, 1'b0);
      chk("R11", 64'({lk_hit, lk_exc, lk_multi, lk_fault}), 64'd0);

      // R5: way 0 was referenced, way 1 fresh -> victim 1
      install(1'b1, 1'b1, 8'd5, 1'b1, 1'b1, 2'b10, 18'h00BBB, 22'h000777);
      look(1'b0, mkva(18'h0, 8'd5, 14'h0), 1'b0, 1'b0);
      chk("R5", 64'(lk_victim), 64'd1);

      // R6: bulk clear -> victim back to way 0
      wipe_refs();
      look(1'b0, mkva(18'h0, 8'd5, 14'h0), 1'b0, 1'b0);
      chk("R6", 64'(lk_victim), 64'd0);

      // R7: unprivileged install ignored
      install(1'b0, 1'b0, 8'd9, 1'b1, 1'b1, 2'b10, 18'h01234, 22'h0ABCD);
      look(1'b1, mkva(18'h01234, 8'd9, 14'h0), 1'b0, 1'b0);
      chk("R7", 64'({lk_hit, lk_fault}), 64'({1'b0, 2'd1}));

      // R8: duplicate tag in both ways -> way 0 result, flag raised
      install(1'b1, 1'b1, 8'd5, 1'b1, 1'b1, 2'b10, 18'h2AAAA, 22'h0F0F0F);
      look(1'b1, mkva(18'h2AAAA, 8'd5, 14'h0042), 1'b0, 1'b0);
      chk("R8", 64'(lk_multi), 64'd1);
      chk("R8", 64'(lk_pa), 64'({22'h155555, 14'h0042}));

      // R3: rights encodings
      install(1'b1, 1'b0, 8'd20, 1'b1, 1'b1, 2'b01, 18'h00D0D, 22'h1);
      look(1'b1, mkva(18'h00D0D, 8'd20, 14'h0), 1'b1, 1'b0);
      chk("R3", 64'({lk_hit, lk_exc, lk_fault}), 64'({1'b0, 1'b1, 2'd2}));
      install(1'b1, 1'b1, 8'd20, 1'b1, 1'b1, 2'b11, 18'h00E0E, 22'h2);
      look(1'b1, mkva(18'h00E0E, 8'd20, 14'h0), 1'b0, 1'b1);
      chk("R3", 64'(lk_fault), 64'd2);
      look(1'b1, mkva(18'h00E0E, 8'd20, 14'h0), 1'b0, 1'b0);
      chk("R3", 64'(lk_hit), 64'd1);
      install(1'b1, 1'b0, 8'd21, 1'b1, 1'b1, 2'b00, 18'h00111, 22'h3);
      look(1'b1, mkva(18'h00111, 8'd21, 14'h0), 1'b0, 1'b0);
      chk("R3", 64'(lk_fault), 64'd2);

      // R4: write to clean page
      install(1'b1, 1'b0, 8'd30, 1'b1, 1'b0, 2'b10, 18'h00F0F, 22'h4);
      look(1'b1, mkva(18'h00F0F, 8'd30, 14'h0), 1'b1, 1'b0);
      chk("R4", 64'({lk_hit, lk_exc, lk_fault}), 64'({1'b0, 1'b1, 2'd3}));
      look(1'b1, mkva(18'h00F0F, 8'd30, 14'h0), 1'b0, 1'b0);
      chk("R4", 64'(lk_hit), 64'd1);

      // Random mix, checked every cycle against the model
      for (int n = 0; n < 4000; n++) begin
         @(posedge clk) #1;
         lk_req    = ($urandom % 10) != 0;
         lk_va     = {18'($urandom % 4), 8'($urandom % 8), 14'($urandom)};
         lk_write  = 1'($urandom);
         lk_user   = 1'($urandom);
         sw_kernel = ($urandom % 5) != 0;
         wr_en     = ($urandom % 4) == 0;
         wr_way    = 1'($urandom);
         wr_set    = 8'($urandom % 8);
         wr_valid  = ($urandom % 8) != 0;
         wr_dirty  = 1'($urandom);
         wr_rights = 2'($urandom);
         wr_tag    = 18'($urandom % 4);
         wr_ppn    = 22'($urandom);
         clr_ref   = ($urandom % 50) == 0;
      end
      @(posedge clk) #1;
      lk_req = 1'b0; wr_en = 1'b0; clr_ref = 1'b0;
      @(negedge clk);
      summary();
      $finish;
   end

endmodule